// File: doc/BRIEF.md
# Serial Clock Half-Period Rate Generator

This block sets the pace of a master-mode serial shift engine. A byte-wide rate register holds two fields. One field selects a linear prescaler that divides the bus clock by 1 to 8. The other field selects a binary divider that divides the result again by 2, 4, and so on up to 256. The full serial bit period is the product of the two divisors, counted in bus cycles.

The output is a single-cycle strobe that marks each half of the serial clock period. The shift engine toggles its clock and moves its data on these strobes. The strobe therefore repeats every product/2 bus cycles. With the smallest setting it fires on every bus cycle, which gives a bit rate of half the bus clock. Two example settings: 0x43 gives a total ratio of 80, so the strobe comes every 40 cycles, and 0x05 gives a ratio of 64, so the strobe comes every 32 cycles.

The shift engine holds the run input high for the length of a frame. While run is low, or while the block is not in master mode, both counters are held at zero and no strobe is produced. The register can be written at any time. The divisors in use are copied from it only while the block is idle, so a new setting applies from the next frame onward.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset the rate register reads 0x00 and half_tick is low.
- R2: Bits 7 and 3 of the rate register always read 0. Bits 6:4 and 2:0 read back the last value written.
- R3: Bits 6:4 (value P) divide the bus clock by P+1. Example: 0x70 gives a strobe every 8 cycles.
- R4: Bits 2:0 (value E) divide further by 2^(E+1). Example: 0x06 gives a strobe every 64 cycles.
- R5: While running, half_tick pulses once every (P+1)*2^E bus cycles. This is 40 cycles for 0x43 and 32 cycles for 0x05.
- R6: A setting of 0x00 makes half_tick high on every cycle of a run.
- R7: No strobe appears while xfer_run is low. The counters restart on each run. The first strobe comes in run cycle H-1, counting from 0, where H is the strobe interval, so the first half period is full length.
- R8: While master_mode is low, no strobe appears even with xfer_run high. The register stays writable and readable.
- R9: A write during a run does not change the strobe interval of that run. The new value applies from the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_we | input | 1 | Write strobe for the rate register |
| rate_wdata | input | 8 | Write data for the rate register |
| rate_rdata | output | 8 | Current rate register contents |
| master_mode | input | 1 | High when the port acts as master |
| xfer_run | input | 1 | High while the shift engine runs a frame |
| half_tick | output | 1 | One-cycle strobe at each serial clock half period |

## Verification
The assertions assume that master_mode and xfer_run are stable for whole frames, and that a frame is ended by dropping xfer_run before a new one starts. The interval check assumes the default combinational strobe variant.

Each frame in the bench is started and stopped at negative clock edges and lasts long enough for at least two strobes. Register writes fall in idle gaps, except for one directed write placed in the middle of a frame. Random settings come from a fixed seed and cover every field value, including the extremes 0x00 and 0x77.

// File: rtl/sclk_rate_pkg.sv
package sclk_rate_pkg;
   // default field widths of the rate register
   localparam int DEF_PRE_W = 3;
   localparam int DEF_EXP_W = 3;

   // register width: two fields plus one reserved bit above each
   function automatic int reg_width(input int pre_w, input int exp_w);
      return pre_w + exp_w + 2;
   endfunction

   // width of the binary stage counter for a given exponent field
   function automatic int stage_width(input int exp_w);
      return (1 << exp_w) - 1;
   endfunction
endpackage

// File: rtl/rate_cfg_reg.sv
module rate_cfg_reg
   import sclk_rate_pkg::*;
#(
   parameter int PRE_W = DEF_PRE_W,
   parameter int EXP_W = DEF_EXP_W,
   localparam int REG_W = reg_width(PRE_W, EXP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             hold,
   output logic [PRE_W-1:0] act_pre,
   output logic [EXP_W-1:0] act_exp
);
   localparam int PRE_LO = EXP_W + 1;
   localparam int PRE_HI = EXP_W + PRE_W;

   logic [PRE_W-1:0] pre_q;
   logic [EXP_W-1:0] exp_q;
   logic [PRE_W-1:0] nxt_pre;
   logic [EXP_W-1:0] nxt_exp;

   always_comb begin
      if (wr_en) begin
         nxt_pre = wr_data[PRE_HI:PRE_LO];
         nxt_exp = wr_data[EXP_W-1:0];
      end else begin
         nxt_pre = pre_q;
         nxt_exp = exp_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
         exp_q <= '0;
      end else begin
         pre_q <= nxt_pre;
         exp_q <= nxt_exp;
      end
   end

   // snapshot follows the register only while idle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_pre <= '0;
         act_exp <= '0;
      end else if (!hold) begin
         act_pre <= nxt_pre;
         act_exp <= nxt_exp;
      end
   end

   always_comb begin
      rd_data                = '0;
      rd_data[EXP_W-1:0]     = exp_q;
      rd_data[PRE_HI:PRE_LO] = pre_q;
   end

   // R2
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[EXP_W-1:0] == $past(wr_data[EXP_W-1:0]))
             && (rd_data[PRE_HI:PRE_LO] == $past(wr_data[PRE_HI:PRE_LO]))
             && (rd_data[EXP_W] == 1'b0) && (rd_data[REG_W-1] == 1'b0));

   // R9
   frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && $past(hold)) |-> ($stable(act_pre) && $stable(act_exp)));
endmodule

// File: rtl/prescale_stage.sv
module prescale_stage #(
   parameter int PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [PRE_W-1:0] sel,
   output logic             tick
);
   logic [PRE_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt_q <= '0;
      else if (cnt_q == sel)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick = !clr && (cnt_q == sel);

   // R3
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt_q <= sel));
endmodule

// File: rtl/binary_stage.sv
module binary_stage
   import sclk_rate_pkg::*;
#(
   parameter int EXP_W = DEF_EXP_W,
   localparam int LIM_W = stage_width(EXP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [EXP_W-1:0] sel,
   output logic             tick
);
   logic [LIM_W:0]   span;
   logic [LIM_W-1:0] lim;
   logic [LIM_W-1:0] cnt_q;

   always_comb begin
      span = ((LIM_W+1)'(1) << sel) - (LIM_W+1)'(1);
      lim  = span[LIM_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt_q <= '0;
      else if (step) begin
         if (cnt_q == lim)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = step && (cnt_q == lim);

   // R4
   exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt_q <= lim));
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
   import sclk_rate_pkg::*;
#(
   parameter int PRE_W    = DEF_PRE_W,
   parameter int EXP_W    = DEF_EXP_W,
   parameter bit REG_TICK = 1'b0,
   localparam int REG_W   = reg_width(PRE_W, EXP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rate_we,
   input  logic [REG_W-1:0] rate_wdata,
   output logic [REG_W-1:0] rate_rdata,
   input  logic             master_mode,
   input  logic             xfer_run,
   output logic             half_tick
);
   localparam int HALF_W = PRE_W + 1 + stage_width(EXP_W);

   generate
      if (PRE_W < 1 || EXP_W < 1 || EXP_W > 5) begin : g_bad_cfg
         $error("sclk_rate_gen: field widths out of range");
      end
   endgenerate

   logic             running;
   logic [PRE_W-1:0] act_pre;
   logic [EXP_W-1:0] act_exp;
   logic             pre_tick;
   logic             raw_tick;

   assign running = xfer_run && master_mode;

   rate_cfg_reg #(.PRE_W(PRE_W), .EXP_W(EXP_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (rate_we),
      .wr_data (rate_wdata),
      .rd_data (rate_rdata),
      .hold    (running),
      .act_pre (act_pre),
      .act_exp (act_exp)
   );

   prescale_stage #(.PRE_W(PRE_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!running),
      .sel   (act_pre),
      .tick  (pre_tick)
   );

   binary_stage #(.EXP_W(EXP_W)) u_bin (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!running),
      .step  (pre_tick),
      .sel   (act_exp),
      .tick  (raw_tick)
   );

   generate
      if (REG_TICK) begin : g_reg_tick
         logic tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               tick_q <= 1'b0;
            else
               tick_q <= raw_tick && running;
         end
         assign half_tick = tick_q;
      end else begin : g_comb_tick
         logic [HALF_W-1:0] gap_q;
         logic [HALF_W-1:0] half_len;

         assign half_tick = raw_tick;

         always_comb begin
            half_len = HALF_W'(act_pre) + HALF_W'(1);
            half_len = half_len << act_exp;
         end

         always_ff @(posedge clk) begin
            if (!rst_n || !running || raw_tick)
               gap_q <= '0;
            else
               gap_q <= gap_q + 1'b1;
         end

         // R5
         interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (running && half_tick) |-> ((gap_q + 1'b1) == half_len));

         // R7
         idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !xfer_run |-> !half_tick);

         // R8
         slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !master_mode |-> !half_tick);
      end
   endgenerate
endmodule

// File: tb/sclk_rate_gen_test.sv
module sclk_rate_gen_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       rate_we;
   logic [7:0] rate_wdata;
   logic [7:0] rate_rdata;
   logic       master_mode;
   logic       xfer_run;
   logic       half_tick;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   sclk_rate_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rate_we     (rate_we),
      .rate_wdata  (rate_wdata),
      .rate_rdata  (rate_rdata),
      .master_mode (master_mode),
      .xfer_run    (xfer_run),
      .half_tick   (half_tick)
   );

   function automatic int half_of(input logic [7:0] v);
      return ((int'(v[6:4]) + 1) << v[2:0]);
   endfunction

   function automatic logic [7:0] masked(input logic [7:0] v);
      return v & 8'h77;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_rate(input logic [7:0] v);
      @(negedge clk);
      rate_we = 1'b1;
      rate_wdata = v;
      @(negedge clk);
      rate_we = 1'b0;
   endtask

   // run a frame of n cycles; report the cycles of the first two strobes
   task automatic run_frame(input int n, input bit mst, output int t0, output int t1);
      t0 = -1;
      t1 = -1;
      @(negedge clk);
      xfer_run = 1'b1;
      master_mode = mst;
      for (int k = 0; k < n; k++) begin
         #1;
         if (half_tick) begin
            if (t0 < 0) t0 = k;
            else if (t1 < 0) t1 = k;
         end
         @(negedge clk);
      end
      xfer_run = 1'b0;
   endtask

   task automatic rate_case(input string req, input logic [7:0] v);
      int h, t0, t1;
      h = half_of(v);
      write_rate(v);
      run_frame(2 * h + 1, 1'b1, t0, t1);
      check({req, " first strobe"}, t0, h - 1);
      check({req, " strobe interval"}, t1 - t0, h);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int t0, t1, ones;
      logic [7:0] v;
      void'($urandom(32'd1234));
      rst_n = 1'b0;
      rate_we = 1'b0;
      rate_wdata = '0;
      master_mode = 1'b1;
      xfer_run = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1
      check("R1 reset value", int'(rate_rdata), 0);
      check("R1 strobe low", int'(half_tick), 0);

      // R2 readback with reserved bits masked
      write_rate(8'hFF);
      #1 check("R2 readback FF", int'(rate_rdata), 8'h77);
      write_rate(8'h88);
      #1 check("R2 readback 88", int'(rate_rdata), 0);

      // R6 fastest setting: strobe every cycle
      write_rate(8'h00);
      ones = 0;
      @(negedge clk);
      xfer_run = 1'b1;
      for (int k = 0; k < 16; k++) begin
         #1 if (half_tick) ones++;
         @(negedge clk);
      end
      xfer_run = 1'b0;
      check("R6 strobes in 16 cycles", ones, 16);

      rate_case("R3", 8'h70);
      rate_case("R4", 8'h06);
      rate_case("R5 0x43", 8'h43);
      rate_case("R5 0x05", 8'h05);
      rate_case("R5 0x77", 8'h77);

      // R7 idle: no strobe with run low
      ones = 0;
      for (int k = 0; k < 20; k++) begin
         #1 if (half_tick) ones++;
         @(negedge clk);
      end
      check("R7 idle strobes", ones, 0);

      // R8 slave mode: no strobe, register still writable
      write_rate(8'h00);
      run_frame(20, 1'b0, t0, t1);
      check("R8 slave strobe", t0, -1);
      master_mode = 1'b1;
      write_rate(8'h31);
      #1 check("R8 register writable", int'(rate_rdata), 8'h31);

      // R9 write during a frame does not change its interval
      write_rate(8'h05);
      t0 = -1;
      t1 = -1;
      @(negedge clk);
      xfer_run = 1'b1;
      for (int k = 0; k < 70; k++) begin
         if (k == 10) rate_we = 1'b1;
         if (k == 10) rate_wdata = 8'h00;
         if (k == 11) rate_we = 1'b0;
         #1;
         if (half_tick) begin
            if (t0 < 0) t0 = k;
            else if (t1 < 0) t1 = k;
         end
         @(negedge clk);
      end
      xfer_run = 1'b0;
      check("R9 first strobe old rate", t0, 31);
      check("R9 interval old rate", t1 - t0, 32);
      run_frame(4, 1'b1, t0, t1);
      check("R9 next frame new rate", t0, 0);
      check("R9 next frame interval", t1 - t0, 1);

      // random settings, R5
      for (int i = 0; i < 24; i++) begin
         v = 8'($urandom());
         rate_case("R5 random", v);
         #1 check("R2 random readback", int'(rate_rdata), int'(masked(v)));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule